// File: doc/BRIEF.md
# Dual-Width External Memory Bus Sequencer

This unit sits between a processor's single load/store request port and two external memory buses. One is a 16-bit program bus with a half-word address and two chip selects. The other is an 8-bit expansion bus with a byte address and seven chip selects. A request carries a byte, half-word or word size. The unit decodes the target bus and chip select from the request address. It splits the transfer into narrow back-to-back beats and drives the active-low strobes. It returns the assembled read data with a one-cycle completion pulse.

Multi-beat transfers do not use the same byte order in both directions. Reads fetch the most significant part first. Writes send the least significant part first. The bus address still rises by one bus unit per beat in both cases. On the expansion bus, each strobe can be stretched by a configurable number of wait cycles. Six of its seven selects can be given over to port use, and a select given over in this way is never asserted.

Top module: `membus_seq`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1, every chip select and strobe is high (inactive), `resp_done` is 0 and both data output enables are 0.
- R2: `req_addr[21]` picks the bus: 0 for the program bus, 1 for the expansion bus. On the program bus, `req_addr[20]` picks `prog_cs_n[0]` or `prog_cs_n[1]` and the half-word address is `req_addr[19:1]`. On the expansion bus, the byte address is `req_addr[15:0]` and the 3-bit index `req_addr[18:16]` picks `data_cs_n[index]` for index 0..6. Index 7 asserts no select.
- R3: When `cfg_port_en[i-1]` is 1, expansion select `i` (i = 1..6) stays high even when it is addressed. The access itself still runs. Select 0 cannot be masked.
- R4: `req_size` codes are 0 for byte, 1 for half-word and 2 or 3 for word. On the program bus, byte and half-word take one beat and a word takes two. On the expansion bus, byte, half-word and word take one, two and four beats.
- R5: A read fills the result from the most significant lane down: beat k lands in lane N-1-k. The result is masked to the request size and zero-extended.
- R6: A write drives lane k of `req_wdata` in beat k, least significant first. The output enable is high during the setup and strobe cycles of write beats only.
- R7: Beat k drives the base address plus k, wrapping at the bus address width. The address is stable for the whole beat.
- R8: Each beat has one setup cycle with the chip select low and the strobe high, followed by 1+W strobe cycles. The chip select stays low from the first setup cycle through one hold cycle after the last strobe. `resp_done` is high for exactly one cycle, N*(2+W)+1 cycles after the accepting clock edge.
- R9: W equals `cfg_wait_cnt` when `cfg_wait_en` is 1 and the target is the expansion bus, and 0 otherwise. The value is sampled at acceptance.
- R10: Only the addressed bus moves. The other bus's strobes stay high for the whole access.
- R11: A request is accepted only while `req_ready` is 1. `req_valid` pulses while busy start no beats, and `req_ready` is 1 whenever `resp_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_ready | output | 1 | Unit is idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Transfer size code |
| req_addr | input | 22 | Bus, select and address fields |
| req_wdata | input | 32 | Write data |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Assembled, size-masked read data |
| cfg_wait_en | input | 1 | Enables expansion-bus wait cycles |
| cfg_wait_cnt | input | 2 | Wait cycles per expansion beat |
| cfg_port_en | input | 6 | Per-select port mode for selects 1..6 |
| prog_addr | output | 19 | Program bus half-word address |
| prog_cs_n | output | 2 | Program bus chip selects, active low |
| prog_rd_n | output | 1 | Program bus read strobe, active low |
| prog_wr_n | output | 1 | Program bus write strobe, active low |
| prog_dq_o | output | 16 | Program bus write data |
| prog_dq_oe | output | 1 | Program bus drive enable |
| prog_dq_i | input | 16 | Program bus read data |
| data_addr | output | 16 | Expansion bus byte address |
| data_cs_n | output | 7 | Expansion bus chip selects, active low |
| data_rd_n | output | 1 | Expansion bus read strobe, active low |
| data_wr_n | output | 1 | Expansion bus write strobe, active low |
| data_dq_o | output | 8 | Expansion bus write data |
| data_dq_oe | output | 1 | Expansion bus drive enable |
| data_dq_i | input | 8 | Expansion bus read data |

## Verification
Completion is due N*(2+W)+1 clock edges after the accepting edge. The bench counts edges from acceptance and compares that count exactly against the formula for every size, bus and wait setting. Strobe widths are measured at falling clock edges and must equal 1+W cycles per beat. Each beat's address, select pattern and write lane are captured at the first falling edge of its strobe. The read result is compared on the same falling edge where the done pulse is first seen. The intrusion test waits four more cycles after completion before it confirms that no extra beat appeared.

// File: rtl/membus_pkg.sv
package membus_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_STRB  = 2'd2,
      ST_HOLD  = 2'd3
   } seq_state_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;

   function automatic int unsigned size_bits(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: return 8;
         SZ_HALF: return 16;
         default: return 32;
      endcase
   endfunction

   function automatic int unsigned beats_for(input logic [1:0] sz, input int unsigned lane_w);
      int unsigned b;
      b = size_bits(sz);
      return (b <= lane_w) ? 1 : (b / lane_w);
   endfunction

endpackage

// File: rtl/membus_decode.sv
module membus_decode
   import membus_pkg::*;
#(
   parameter int REQ_AW   = 22,
   parameter int PROG_AW  = 19,
   parameter int PROG_DW  = 16,
   parameter int PROG_NCS = 2,
   parameter int DATA_AW  = 16,
   parameter int DATA_DW  = 8,
   parameter int DATA_NCS = 7,
   parameter int BEAT_W   = 2
) (
   input  logic [REQ_AW-1:0]   req_addr,
   input  logic [1:0]          req_size,
   input  logic [DATA_NCS-2:0] port_en,
   output logic                to_data,
   output logic [PROG_NCS-1:0] prog_sel,
   output logic [DATA_NCS-1:0] data_sel,
   output logic [PROG_AW-1:0]  prog_a,
   output logic [DATA_AW-1:0]  data_a,
   output logic [BEAT_W-1:0]   last_beat
);
   localparam int PROG_OFS = $clog2(PROG_DW / 8);
   localparam int PROG_CSB = (PROG_NCS > 1) ? $clog2(PROG_NCS) : 1;
   localparam int DATA_CSB = $clog2(DATA_NCS + 1);

   logic [PROG_CSB-1:0] pidx;
   logic [DATA_CSB-1:0] didx;

   assign to_data = req_addr[REQ_AW-1];
   assign prog_a  = req_addr[PROG_OFS +: PROG_AW];
   assign pidx    = req_addr[PROG_OFS + PROG_AW +: PROG_CSB];
   assign data_a  = req_addr[0 +: DATA_AW];
   assign didx    = req_addr[DATA_AW +: DATA_CSB];

   for (genvar i = 0; i < PROG_NCS; i++) begin : g_psel
      assign prog_sel[i] = (pidx == PROG_CSB'(i));
   end

   for (genvar i = 0; i < DATA_NCS; i++) begin : g_dsel
      if (i == 0) begin : g_fixed
         assign data_sel[i] = (didx == DATA_CSB'(i));
      end else begin : g_shared
         assign data_sel[i] = (didx == DATA_CSB'(i)) & ~port_en[i-1];
      end
   end

   always_comb begin
      int unsigned nb;
      nb = beats_for(req_size, to_data ? DATA_DW : PROG_DW);
      last_beat = BEAT_W'(nb - 1);
   end

endmodule

// File: rtl/membus_lane.sv
module membus_lane #(
   parameter int WORD_W = 32,
   parameter int LANE_W = 16,
   parameter int BEAT_W = 2
) (
   input  logic [WORD_W-1:0] word_wr,
   input  logic [WORD_W-1:0] acc,
   input  logic [LANE_W-1:0] bus_in,
   input  logic [BEAT_W-1:0] lane,
   output logic [LANE_W-1:0] lane_out,
   output logic [WORD_W-1:0] acc_next
);
   localparam int NL = WORD_W / LANE_W;

   for (genvar l = 0; l < NL; l++) begin : g_merge
      assign acc_next[l*LANE_W +: LANE_W] =
         (lane == BEAT_W'(l)) ? bus_in : acc[l*LANE_W +: LANE_W];
   end

   always_comb begin
      lane_out = word_wr[LANE_W-1:0];
      for (int l = 0; l < NL; l++) begin
         if (lane == BEAT_W'(l)) lane_out = word_wr[l*LANE_W +: LANE_W];
      end
   end

endmodule

// File: rtl/membus_ctrl.sv
module membus_ctrl
   import membus_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int PROG_AW  = 19,
   parameter int PROG_NCS = 2,
   parameter int DATA_AW  = 16,
   parameter int DATA_NCS = 7,
   parameter int WAIT_W   = 2,
   parameter int BEAT_W   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [1:0]          req_size,
   input  logic [WORD_W-1:0]   req_wdata,
   input  logic                dec_to_data,
   input  logic [PROG_NCS-1:0] dec_prog_sel,
   input  logic [DATA_NCS-1:0] dec_data_sel,
   input  logic [PROG_AW-1:0]  dec_prog_a,
   input  logic [DATA_AW-1:0]  dec_data_a,
   input  logic [BEAT_W-1:0]   dec_last,
   input  logic                cfg_wait_en,
   input  logic [WAIT_W-1:0]   cfg_wait_cnt,
   input  logic [WORD_W-1:0]   acc_next_p,
   input  logic [WORD_W-1:0]   acc_next_d,
   output seq_state_e          st,
   output logic [BEAT_W-1:0]   lane,
   output logic                cur_to_data,
   output logic                cur_write,
   output logic [1:0]          cur_size,
   output logic [WORD_W-1:0]   cur_wdata,
   output logic [PROG_NCS-1:0] cur_prog_sel,
   output logic [DATA_NCS-1:0] cur_data_sel,
   output logic [PROG_AW-1:0]  cur_prog_a,
   output logic [DATA_AW-1:0]  cur_data_a,
   output logic [WORD_W-1:0]   acc,
   output logic                done
);
   seq_state_e          st_q;
   logic [BEAT_W-1:0]   beat_q, last_q;
   logic [WAIT_W-1:0]   wcnt_q, wlim_q;
   logic                td_q, wr_q;
   logic [1:0]          sz_q;
   logic [WORD_W-1:0]   wd_q, acc_q;
   logic [PROG_NCS-1:0] psel_q;
   logic [DATA_NCS-1:0] dsel_q;
   logic [PROG_AW-1:0]  pa_q;
   logic [DATA_AW-1:0]  da_q;
   logic                done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         beat_q <= '0;
         last_q <= '0;
         wcnt_q <= '0;
         wlim_q <= '0;
         td_q   <= 1'b0;
         wr_q   <= 1'b0;
         sz_q   <= '0;
         wd_q   <= '0;
         acc_q  <= '0;
         psel_q <= '0;
         dsel_q <= '0;
         pa_q   <= '0;
         da_q   <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  st_q   <= ST_SETUP;
                  beat_q <= '0;
                  last_q <= dec_last;
                  wcnt_q <= '0;
                  wlim_q <= (dec_to_data && cfg_wait_en) ? cfg_wait_cnt : '0;
                  td_q   <= dec_to_data;
                  wr_q   <= req_write;
                  sz_q   <= req_size;
                  wd_q   <= req_wdata;
                  acc_q  <= '0;
                  psel_q <= dec_prog_sel;
                  dsel_q <= dec_data_sel;
                  pa_q   <= dec_prog_a;
                  da_q   <= dec_data_a;
               end
            end
            ST_SETUP: begin
               st_q   <= ST_STRB;
               wcnt_q <= '0;
            end
            ST_STRB: begin
               if (wcnt_q == wlim_q) begin
                  if (!wr_q) acc_q <= td_q ? acc_next_d : acc_next_p;
                  if (beat_q == last_q) begin
                     st_q <= ST_HOLD;
                  end else begin
                     beat_q <= beat_q + 1'b1;
                     st_q   <= ST_SETUP;
                  end
               end else begin
                  wcnt_q <= wcnt_q + 1'b1;
               end
            end
            default: begin
               st_q   <= ST_IDLE;
               done_q <= 1'b1;
            end
         endcase
      end
   end

   assign st           = st_q;
   assign lane         = wr_q ? beat_q : (last_q - beat_q);
   assign cur_to_data  = td_q;
   assign cur_write    = wr_q;
   assign cur_size     = sz_q;
   assign cur_wdata    = wd_q;
   assign cur_prog_sel = psel_q;
   assign cur_data_sel = dsel_q;
   assign cur_prog_a   = pa_q + {{(PROG_AW-BEAT_W){1'b0}}, beat_q};
   assign cur_data_a   = da_q + {{(DATA_AW-BEAT_W){1'b0}}, beat_q};
   assign acc          = acc_q;
   assign done         = done_q;

endmodule

// File: rtl/membus_seq.sv
module membus_seq
   import membus_pkg::*;
#(
   parameter int REQ_AW   = 22,
   parameter int WORD_W   = 32,
   parameter int PROG_AW  = 19,
   parameter int PROG_DW  = 16,
   parameter int PROG_NCS = 2,
   parameter int DATA_AW  = 16,
   parameter int DATA_DW  = 8,
   parameter int DATA_NCS = 7,
   parameter int WAIT_W   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [1:0]          req_size,
   input  logic [REQ_AW-1:0]   req_addr,
   input  logic [WORD_W-1:0]   req_wdata,
   output logic                resp_done,
   output logic [WORD_W-1:0]   resp_rdata,
   input  logic                cfg_wait_en,
   input  logic [WAIT_W-1:0]   cfg_wait_cnt,
   input  logic [DATA_NCS-2:0] cfg_port_en,
   output logic [PROG_AW-1:0]  prog_addr,
   output logic [PROG_NCS-1:0] prog_cs_n,
   output logic                prog_rd_n,
   output logic                prog_wr_n,
   output logic [PROG_DW-1:0]  prog_dq_o,
   output logic                prog_dq_oe,
   input  logic [PROG_DW-1:0]  prog_dq_i,
   output logic [DATA_AW-1:0]  data_addr,
   output logic [DATA_NCS-1:0] data_cs_n,
   output logic                data_rd_n,
   output logic                data_wr_n,
   output logic [DATA_DW-1:0]  data_dq_o,
   output logic                data_dq_oe,
   input  logic [DATA_DW-1:0]  data_dq_i
);
   localparam int MIN_DW   = (PROG_DW < DATA_DW) ? PROG_DW : DATA_DW;
   localparam int MAX_BT   = WORD_W / MIN_DW;
   localparam int BEAT_W   = (MAX_BT > 1) ? $clog2(MAX_BT) : 1;
   localparam int PROG_OFS = $clog2(PROG_DW / 8);
   localparam int PROG_CSB = (PROG_NCS > 1) ? $clog2(PROG_NCS) : 1;
   localparam int DATA_CSB = $clog2(DATA_NCS + 1);
   localparam int NEED_P   = PROG_OFS + PROG_AW + PROG_CSB;
   localparam int NEED_D   = DATA_AW + DATA_CSB;
   localparam int NEED_AW  = 1 + ((NEED_P > NEED_D) ? NEED_P : NEED_D);

   if (WORD_W != 32) begin : g_bad_word
      $error("membus_seq: WORD_W must be 32");
   end
   if ((WORD_W % PROG_DW) != 0 || (WORD_W % DATA_DW) != 0 || DATA_DW < 8 || PROG_DW < 8) begin : g_bad_lane
      $error("membus_seq: lane widths must divide the word and be at least a byte");
   end
   if (REQ_AW < NEED_AW) begin : g_bad_aw
      $error("membus_seq: REQ_AW too small for the address fields");
   end
   if (PROG_AW <= BEAT_W || DATA_AW <= BEAT_W || DATA_NCS < 2) begin : g_bad_geom
      $error("membus_seq: bus geometry out of range");
   end

   logic                dec_to_data;
   logic [PROG_NCS-1:0] dec_prog_sel;
   logic [DATA_NCS-1:0] dec_data_sel;
   logic [PROG_AW-1:0]  dec_prog_a;
   logic [DATA_AW-1:0]  dec_data_a;
   logic [BEAT_W-1:0]   dec_last;

   seq_state_e          st;
   logic [BEAT_W-1:0]   lane;
   logic                cur_to_data, cur_write;
   logic [1:0]          cur_size;
   logic [WORD_W-1:0]   cur_wdata, acc, acc_next_p, acc_next_d;
   logic [PROG_NCS-1:0] cur_prog_sel;
   logic [DATA_NCS-1:0] cur_data_sel;
   logic [PROG_AW-1:0]  cur_prog_a;
   logic [DATA_AW-1:0]  cur_data_a;
   logic                done;
   logic [PROG_DW-1:0]  p_lane_out;
   logic [DATA_DW-1:0]  d_lane_out;

   membus_decode #(
      .REQ_AW(REQ_AW), .PROG_AW(PROG_AW), .PROG_DW(PROG_DW), .PROG_NCS(PROG_NCS),
      .DATA_AW(DATA_AW), .DATA_DW(DATA_DW), .DATA_NCS(DATA_NCS), .BEAT_W(BEAT_W)
   ) i_decode (
      .req_addr (req_addr),
      .req_size (req_size),
      .port_en  (cfg_port_en),
      .to_data  (dec_to_data),
      .prog_sel (dec_prog_sel),
      .data_sel (dec_data_sel),
      .prog_a   (dec_prog_a),
      .data_a   (dec_data_a),
      .last_beat(dec_last)
   );

   membus_ctrl #(
      .WORD_W(WORD_W), .PROG_AW(PROG_AW), .PROG_NCS(PROG_NCS), .DATA_AW(DATA_AW),
      .DATA_NCS(DATA_NCS), .WAIT_W(WAIT_W), .BEAT_W(BEAT_W)
   ) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_size    (req_size),
      .req_wdata   (req_wdata),
      .dec_to_data (dec_to_data),
      .dec_prog_sel(dec_prog_sel),
      .dec_data_sel(dec_data_sel),
      .dec_prog_a  (dec_prog_a),
      .dec_data_a  (dec_data_a),
      .dec_last    (dec_last),
      .cfg_wait_en (cfg_wait_en),
      .cfg_wait_cnt(cfg_wait_cnt),
      .acc_next_p  (acc_next_p),
      .acc_next_d  (acc_next_d),
      .st          (st),
      .lane        (lane),
      .cur_to_data (cur_to_data),
      .cur_write   (cur_write),
      .cur_size    (cur_size),
      .cur_wdata   (cur_wdata),
      .cur_prog_sel(cur_prog_sel),
      .cur_data_sel(cur_data_sel),
      .cur_prog_a  (cur_prog_a),
      .cur_data_a  (cur_data_a),
      .acc         (acc),
      .done        (done)
   );

   membus_lane #(.WORD_W(WORD_W), .LANE_W(PROG_DW), .BEAT_W(BEAT_W)) i_prog_lane (
      .word_wr (cur_wdata),
      .acc     (acc),
      .bus_in  (prog_dq_i),
      .lane    (lane),
      .lane_out(p_lane_out),
      .acc_next(acc_next_p)
   );

   membus_lane #(.WORD_W(WORD_W), .LANE_W(DATA_DW), .BEAT_W(BEAT_W)) i_data_lane (
      .word_wr (cur_wdata),
      .acc     (acc),
      .bus_in  (data_dq_i),
      .lane    (lane),
      .lane_out(d_lane_out),
      .acc_next(acc_next_d)
   );

   logic busy, p_act, d_act, strb, drive;
   logic [WORD_W-1:0] size_mask;

   assign busy  = (st != ST_IDLE);
   assign p_act = busy & ~cur_to_data;
   assign d_act = busy & cur_to_data;
   assign strb  = (st == ST_STRB);
   assign drive = cur_write & ((st == ST_SETUP) | (st == ST_STRB));

   always_comb begin
      case (cur_size)
         SZ_BYTE: size_mask = {{(WORD_W-8){1'b0}}, 8'hFF};
         SZ_HALF: size_mask = {{(WORD_W-16){1'b0}}, 16'hFFFF};
         default: size_mask = '1;
      endcase
   end

   assign req_ready  = ~busy;
   assign resp_done  = done;
   assign resp_rdata = acc & size_mask;

   assign prog_addr  = cur_prog_a;
   assign prog_cs_n  = ~(cur_prog_sel & {PROG_NCS{p_act}});
   assign prog_rd_n  = ~(p_act & strb & ~cur_write);
   assign prog_wr_n  = ~(p_act & strb & cur_write);
   assign prog_dq_o  = p_lane_out;
   assign prog_dq_oe = p_act & drive;

   assign data_addr  = cur_data_a;
   assign data_cs_n  = ~(cur_data_sel & {DATA_NCS{d_act}});
   assign data_rd_n  = ~(d_act & strb & ~cur_write);
   assign data_wr_n  = ~(d_act & strb & cur_write);
   assign data_dq_o  = d_lane_out;
   assign data_dq_oe = d_act & drive;

endmodule

// File: rtl/membus_seq_chk.sv
module membus_seq_chk #(
   parameter int PROG_AW  = 19,
   parameter int PROG_NCS = 2,
   parameter int DATA_AW  = 16,
   parameter int DATA_NCS = 7
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_ready,
   input logic                resp_done,
   input logic [PROG_AW-1:0]  prog_addr,
   input logic [PROG_NCS-1:0] prog_cs_n,
   input logic                prog_rd_n,
   input logic                prog_wr_n,
   input logic                prog_dq_oe,
   input logic [DATA_AW-1:0]  data_addr,
   input logic [DATA_NCS-1:0] data_cs_n,
   input logic                data_rd_n,
   input logic                data_wr_n,
   input logic                data_dq_oe
);
   // R1
   rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((!prog_rd_n && !prog_wr_n) || (!data_rd_n && !data_wr_n)));

   // R8
   strobe_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_rd_n || !prog_wr_n) |-> (prog_cs_n != '1));

   // R8
   select_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_rd_n) |-> ($past(prog_cs_n) != '1));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_done |=> !resp_done);

   // R10
   one_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((!prog_rd_n || !prog_wr_n) && (!data_rd_n || !data_wr_n)));

   // R6
   drive_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_dq_oe |-> prog_rd_n) and (data_dq_oe |-> data_rd_n));

   // R7
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!data_rd_n && $past(!data_rd_n)) |-> $stable(data_addr));

   // R7
   prog_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_wr_n && $past(!prog_wr_n)) |-> $stable(prog_addr));

   // R11
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_done |-> req_ready);

   // R3
   data_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~data_cs_n));

endmodule

bind membus_seq membus_seq_chk #(
   .PROG_AW(PROG_AW), .PROG_NCS(PROG_NCS), .DATA_AW(DATA_AW), .DATA_NCS(DATA_NCS)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .resp_done (resp_done),
   .prog_addr (prog_addr),
   .prog_cs_n (prog_cs_n),
   .prog_rd_n (prog_rd_n),
   .prog_wr_n (prog_wr_n),
   .prog_dq_oe(prog_dq_oe),
   .data_addr (data_addr),
   .data_cs_n (data_cs_n),
   .data_rd_n (data_rd_n),
   .data_wr_n (data_wr_n),
   .data_dq_oe(data_dq_oe)
);

// File: tb/test_membus_seq.sv
module test_membus_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [21:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        resp_done;
   logic [31:0] resp_rdata;
   logic        cfg_wait_en = 1'b0;
   logic [1:0]  cfg_wait_cnt = 2'd0;
   logic [5:0]  cfg_port_en = 6'b010100;
   logic [18:0] prog_addr;
   logic [1:0]  prog_cs_n;
   logic        prog_rd_n, prog_wr_n, prog_dq_oe;
   logic [15:0] prog_dq_o, prog_dq_i;
   logic [15:0] data_addr;
   logic [6:0]  data_cs_n;
   logic        data_rd_n, data_wr_n, data_dq_oe;
   logic [7:0]  data_dq_o, data_dq_i;

   always #5 clk = ~clk;

   membus_seq i_membus_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .resp_done(resp_done), .resp_rdata(resp_rdata),
      .cfg_wait_en(cfg_wait_en), .cfg_wait_cnt(cfg_wait_cnt), .cfg_port_en(cfg_port_en),
      .prog_addr(prog_addr), .prog_cs_n(prog_cs_n), .prog_rd_n(prog_rd_n),
      .prog_wr_n(prog_wr_n), .prog_dq_o(prog_dq_o), .prog_dq_oe(prog_dq_oe),
      .prog_dq_i(prog_dq_i),
      .data_addr(data_addr), .data_cs_n(data_cs_n), .data_rd_n(data_rd_n),
      .data_wr_n(data_wr_n), .data_dq_o(data_dq_o), .data_dq_oe(data_dq_oe),
      .data_dq_i(data_dq_i)
   );

   function automatic logic [15:0] pmem(input logic [18:0] a);
      logic [31:0] t;
      t = {13'd0, a} * 32'd40503 + 32'h1234;
      return t[15:0];
   endfunction

   function automatic logic [7:0] dmem(input logic [15:0] a);
      logic [31:0] t;
      t = {16'd0, a} * 32'd37 + 32'd11;
      return t[7:0];
   endfunction

   assign prog_dq_i = pmem(prog_addr);
   assign data_dq_i = dmem(data_addr);

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit finished = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000 && !finished) begin
         finished = 1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // Beat monitor: logs each strobe of the targeted bus at falling edges
   bit          cur_td = 0;
   bit          xbus = 0;
   bit          prev_s = 0;
   int          nlog = 0;
   logic [18:0] log_addr [0:3];
   logic [15:0] log_dat  [0:3];
   logic [6:0]  log_cs   [0:3];
   logic        log_oe   [0:3];
   int          log_len  [0:3];

   always @(negedge clk) begin
      bit s, o;
      s = cur_td ? !(data_rd_n && data_wr_n) : !(prog_rd_n && prog_wr_n);
      o = cur_td ? !(prog_rd_n && prog_wr_n) : !(data_rd_n && data_wr_n);
      if (o) xbus = 1;
      if (s && !prev_s) begin
         if (nlog < 4) begin
            log_addr[nlog] = cur_td ? {3'd0, data_addr} : prog_addr;
            log_dat[nlog]  = cur_td ? {8'd0, data_dq_o} : prog_dq_o;
            log_cs[nlog]   = cur_td ? data_cs_n : {5'h1F, prog_cs_n};
            log_oe[nlog]   = cur_td ? data_dq_oe : prog_dq_oe;
            log_len[nlog]  = 1;
         end
         nlog++;
      end else if (s && nlog >= 1 && nlog <= 4) begin
         log_len[nlog-1]++;
      end
      prev_s = s;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic idle_checks(input string tag);
      chk(req_ready === 1'b1, "R1", {tag, " ready"}, 32'(req_ready), 32'd1);
      chk(prog_cs_n === 2'b11 && data_cs_n === 7'h7F, "R1", {tag, " selects"},
          {prog_cs_n, data_cs_n}, 32'h1FF);
      chk({prog_rd_n, prog_wr_n, data_rd_n, data_wr_n} === 4'hF, "R1", {tag, " strobes"},
          32'({prog_rd_n, prog_wr_n, data_rd_n, data_wr_n}), 32'hF);
      chk(resp_done === 1'b0 && prog_dq_oe === 1'b0 && data_dq_oe === 1'b0, "R1",
          {tag, " done/oe"}, 32'({resp_done, prog_dq_oe, data_dq_oe}), 32'd0);
   endtask

   task automatic xfer(input bit td, input int csx, input logic [18:0] base,
                       input logic [1:0] sz, input bit wr, input logic [31:0] wd,
                       input bit wen, input logic [1:0] wc, input bit intrude);
      int n, w, lw, lat, c0, guard;
      logic [31:0] exp_rd, mask;
      logic [6:0]  exp_cs;
      logic [18:0] ea;
      logic [15:0] ed, bv;
      lw = td ? 8 : 16;
      n  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? (td ? 2 : 1) : (td ? 4 : 2);
      w  = (td && wen) ? int'(wc) : 0;
      mask = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
      if (td) begin
         exp_cs = 7'h7F;
         if (csx < 7 && !(csx >= 1 && cfg_port_en[csx-1])) exp_cs[csx] = 1'b0;
      end else begin
         exp_cs = 7'h7F;
         exp_cs[csx] = 1'b0;
      end
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      cur_td = td; xbus = 0; nlog = 0;
      cfg_wait_en = wen; cfg_wait_cnt = wc;
      req_write = wr; req_size = sz; req_wdata = wd;
      if (td) req_addr = {1'b1, 2'b00, 3'(csx), base[15:0]};
      else    req_addr = {1'b0, 1'(csx), base, 1'b1};
      req_valid = 1'b1;
      @(negedge clk);
      c0 = cyc;
      req_valid = 1'b0;
      guard = 0;
      while (!resp_done && guard < 300) begin
         @(negedge clk);
         guard++;
         if (intrude) begin
            if (guard == 2) begin
               req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2;
               req_addr = {1'b0, 1'b1, 19'h00100, 1'b0};
            end
            if (guard == 5) req_valid = 1'b0;
         end
      end
      lat = cyc - c0;
      // R8 R9: completion latency includes the wait cycles of the target bus
      chk(lat == n * (2 + w) + 1, "R8/R9", "done latency", 32'(lat), 32'(n * (2 + w) + 1));
      // R4
      chk(nlog == n, "R4", "beat count", 32'(nlog), 32'(n));
      // R10
      chk(xbus == 0, "R10", "other bus strobed", 32'(xbus), 32'd0);
      exp_rd = '0;
      for (int k = 0; k < n && k < 4; k++) begin
         ea = td ? {3'd0, 16'(base[15:0] + 16'(k))} : 19'(base + 19'(k));
         // R7
         chk(log_addr[k] == ea, "R7", "beat address", 32'(log_addr[k]), 32'(ea));
         // R2 R3
         chk(log_cs[k] == exp_cs, "R2/R3", "select pattern", 32'(log_cs[k]), 32'(exp_cs));
         // R8 R9
         chk(log_len[k] == 1 + w, "R8/R9", "strobe width", 32'(log_len[k]), 32'(1 + w));
         // R6
         chk(log_oe[k] == wr, "R6", "drive enable", 32'(log_oe[k]), 32'(wr));
         bv = td ? {8'd0, dmem(ea[15:0])} : pmem(ea);
         exp_rd = exp_rd | (32'(bv) << ((n - 1 - k) * lw));
         if (wr) begin
            ed = td ? {8'd0, wd[k*8 +: 8]} : wd[k*16 +: 16];
            // R6
            chk(log_dat[k] == ed, "R6", "write lane order", 32'(log_dat[k]), 32'(ed));
         end
      end
      if (!wr) begin
         exp_rd = exp_rd & mask;
         // R5
         chk(resp_rdata === exp_rd, "R5", "read assembly", resp_rdata, exp_rd);
      end
      // R11
      chk(req_ready === 1'b1, "R11", "ready with done", 32'(req_ready), 32'd1);
      if (intrude) begin
         repeat (4) @(negedge clk);
         // R11: intruding request started nothing
         chk(nlog == n && xbus == 0 && req_ready === 1'b1, "R11", "busy request ignored",
             32'({nlog[7:0], 7'd0, xbus, 7'd0, req_ready}), 32'({8'(n), 16'd1}));
      end
   endtask

   initial begin
      int it;
      logic [18:0] b;
      repeat (3) @(negedge clk);
      idle_checks("in reset");
      rst_n = 1'b1;
      @(negedge clk);
      idle_checks("after reset");
      it = 0;
      for (int td = 0; td < 2; td++)
         for (int sz = 0; sz < 3; sz++)
            for (int wr = 0; wr < 2; wr++)
               for (int w = -1; w < 4; w++) begin
                  if (td == 0 && w > 0) continue;
                  if (td == 1) b = (it == 20) ? 19'h0FFFE : 19'(16'h2000 + it * 9);
                  else         b = 19'(19'h10000 + it * 5);
                  xfer(td[0], td ? (it % 8) : (it % 2), b, 2'(sz), wr[0],
                       32'hA1B2_C3D4 ^ (32'(it) * 32'h0101_0101),
                       (w >= 0), (w >= 0) ? 2'(w) : 2'd2, 1'b0);
                  it++;
               end
      // R3: masked select 3 stays high; unmasked it goes low
      cfg_port_en = 6'b000100;
      xfer(1'b1, 3, 19'h00345, 2'd1, 1'b0, 32'h0, 1'b0, 2'd0, 1'b0);
      cfg_port_en = 6'b000000;
      xfer(1'b1, 3, 19'h00345, 2'd1, 1'b0, 32'h0, 1'b0, 2'd0, 1'b0);
      xfer(1'b1, 6, 19'h00777, 2'd0, 1'b1, 32'h5A, 1'b1, 2'd1, 1'b0);
      // R11: request pulsed while busy
      xfer(1'b1, 0, 19'h01230, 2'd2, 1'b1, 32'hDEAD_BEEF, 1'b1, 2'd3, 1'b1);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule